// File: doc/BRIEF.md
# Straddled Completion Stream Splitter

This block sits on a 256-bit receive path whose source packs completion packets back to back with no gaps. In that stream a beat can hold the last Dwords of one packet and the first Dwords of the next, so the source's keep and last signals carry no framing. Framing comes only from sideband fields that give positions. Two start flags report packet heads, and two 4-bit tail fields report packet ends. In each tail field, bit 0 says the field is valid and bits 3:1 give the Dword index of the last Dword.

The block turns this into an ordinary stream that carries one packet at a time. Every packet's first Dword appears in output Dword 0, output keep marks the Dwords that are valid, and output last marks the final beat of each packet. When a packet begins at Dword 4, the block realigns it through a half-beat carry register. When one input beat yields two output beats, the block holds that input beat until both output beats have been accepted. Both ports use valid/ready flow control. A sticky flag reports sideband combinations that cannot occur on a legal stream.

Top module: `strsp_splitter`

## Requirements
- R1: After reset, out_valid and err_flag are 0, and no packet is in progress.
- R2: Outside a packet, a beat with head_lo=1 starts a packet at Dword 0. That packet's beats are passed through in place, with output Dword i taken from input Dword i.
- R3: A packet that starts at Dword 4 is realigned. This happens on head_lo=1 while a packet is in progress, or on head_hi=1 together with head_lo=1. Output beat n of the packet holds packet Dwords 8n to 8n+7 in Dwords 0 to 7.
- R4: A realigned packet whose tail falls at Dword 4 to 7 of an input beat produces one extra final output beat. That beat carries the input Dwords 4 up to the tail in output Dwords 0 up to tail-4.
- R5: An input beat is accepted (in_ready=1) only on the cycle when the last output beat that needs it is accepted. A beat that produces two output beats is held across two output handshakes.
- R6: out_keep (bit i for output Dword i) is contiguous from bit 0, and it has exactly as many ones as the beat has valid packet Dwords.
- R7: in_keep and in_last have no effect on any output.
- R8: While out_valid=1 and out_ready=0, out_data, out_keep and out_last stay unchanged. This assumes the source holds its beat.
- R9: A valid input beat outside a packet with neither head flag set is accepted without producing an output beat.
- R10: err_flag is set by any of the following, and it stays set until reset:
  - head_hi without head_lo;
  - tail_b valid without tail_a valid;
  - a valid tail_b whose offset is not 6 or 7;
  - a second packet start whose preceding tail is missing or lies beyond Dword 3;
  - a tail with no packet.
- R11: out_last is 1 on the output beat that holds a packet's final Dword and 0 on every other beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 256 | Straddled input beat, eight Dwords |
| in_keep | input | 8 | Input keep, ignored |
| in_last | input | 1 | Input last, ignored |
| in_head_lo | input | 1 | A packet starts in this beat |
| in_head_hi | input | 1 | A second packet starts at Dword 4 |
| in_tail_a | input | 4 | First tail: bit 0 valid, bits 3:1 last Dword index |
| in_tail_b | input | 4 | Second tail: bit 0 valid, bits 3:1 last Dword index |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted |
| out_data | output | 256 | Output beat, packet-aligned |
| out_keep | output | 8 | Valid Dwords of the output beat |
| out_last | output | 1 | Final beat of a packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| err_flag | output | 1 | Sticky sideband consistency error |

## Verification
The hardest case to reach is a beat in which a realigned packet closes at Dword 3 or lower and a new realigned packet opens at Dword 4, while the sink stalls between the two output beats. The bench reaches it by packing a sweep of packet lengths back to back, so that the tails land on every Dword offset and alternate between straddled and fresh starts. It applies pseudo-random stalls on both ports. For each input beat, the expected count of output beats that must be accepted before that beat is consumed comes from the packing arithmetic.

// File: rtl/strsp_pkg.sv
`timescale 1ns/1ps
package strsp_pkg;
   localparam int unsigned LANES = 8;
   localparam int unsigned HALF_LANES = LANES / 2;

   typedef struct packed {
      logic       head_lo;
      logic       head_hi;
      logic [3:0] tail_a;
      logic [3:0] tail_b;
   } strsp_band_t;

   // mask with Dword bits 0..lim set
   function automatic logic [LANES-1:0] keep_upto(input logic [2:0] lim);
      logic [LANES-1:0] m;
      for (int i = 0; i < int'(LANES); i++) m[i] = (i <= int'(lim));
      return m;
   endfunction
endpackage

// File: rtl/strsp_decode.sv
`timescale 1ns/1ps
module strsp_decode
   import strsp_pkg::*;
(
   input  strsp_band_t      band,
   input  logic             act,
   input  logic             shf,
   output logic             first_ok,
   output logic             first_shift,
   output logic [LANES-1:0] first_keep,
   output logic             first_last,
   output logic             second_ok,
   output logic [LANES-1:0] second_keep,
   output logic             nx_act,
   output logic             nx_shf,
   output logic             load_carry,
   output logic             bad
);
   logic       a_v, b_v, start_hi, flush;
   logic [2:0] a_off, b_off;

   assign a_v   = band.tail_a[0];
   assign b_v   = band.tail_b[0];
   assign a_off = band.tail_a[3:1];
   assign b_off = band.tail_b[3:1];

   // a packet at Dword 4: after a continuing packet, or as second head
   assign start_hi    = act ? band.head_lo : band.head_hi;
   assign first_ok    = act | band.head_lo;
   assign first_shift = act & shf;
   assign flush       = first_shift & a_v & a_off[2];
   assign second_ok   = flush | (start_hi & b_v);

   always_comb begin
      if (first_shift) begin
         first_last = a_v & ~a_off[2];
         first_keep = first_last ? keep_upto({1'b1, a_off[1:0]}) : '1;
      end else begin
         first_last = a_v;
         first_keep = a_v ? keep_upto(a_off) : '1;
      end
      second_keep = keep_upto({1'b0, flush ? a_off[1:0] : b_off[1:0]});
   end

   always_comb begin
      nx_act     = 1'b0;
      nx_shf     = 1'b0;
      load_carry = 1'b0;
      if (start_hi) begin
         nx_act     = ~b_v;
         nx_shf     = 1'b1;
         load_carry = ~b_v;
      end else if (first_ok) begin
         nx_act     = ~a_v;
         nx_shf     = act & shf & ~a_v;
         load_carry = first_shift & ~a_v;
      end
   end

   assign bad = (band.head_hi & ~band.head_lo)
              | (b_v & ~a_v)
              | (b_v & (b_off[2:1] != 2'b11))
              | (b_v & ~start_hi)
              | (act & band.head_hi)
              | (start_hi & (~a_v | a_off[2]))
              | (~act & ~band.head_lo & a_v);
endmodule

// File: rtl/strsp_ctrl.sv
`timescale 1ns/1ps
module strsp_ctrl #(
   parameter int unsigned HALF_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              out_ready,
   input  logic              first_ok,
   input  logic              second_ok,
   input  logic              nx_act,
   input  logic              nx_shf,
   input  logic              load_carry,
   input  logic              bad,
   input  logic [HALF_W-1:0] in_hi,
   output logic              in_ready,
   output logic              out_valid,
   output logic              pick_second,
   output logic              act_q,
   output logic              shf_q,
   output logic [HALF_W-1:0] carry_q,
   output logic              err_q
);
   logic step_q, two, any_out, final_step, consume;

   assign two         = first_ok & second_ok;
   assign any_out     = first_ok | second_ok;
   assign final_step  = step_q | ~two;
   assign pick_second = step_q | ~first_ok;
   assign out_valid   = in_valid & any_out;
   assign in_ready    = ~any_out | (out_ready & final_step);
   assign consume     = in_valid & in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q  <= 1'b0;
         act_q   <= 1'b0;
         shf_q   <= 1'b0;
         err_q   <= 1'b0;
         carry_q <= '0;
      end else begin
         if (consume) begin
            step_q <= 1'b0;
            act_q  <= nx_act;
            shf_q  <= nx_shf;
            if (load_carry) carry_q <= in_hi;
         end else if (in_valid && out_ready && two && !step_q) begin
            step_q <= 1'b1;
         end
         if (in_valid && bad) err_q <= 1'b1;
      end
   end

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R10
   AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && two && !step_q) |-> !in_ready); // R5
   AST_STEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      step_q |-> in_valid); // R5
endmodule

// File: rtl/strsp_splitter.sv
`timescale 1ns/1ps
module strsp_splitter
   import strsp_pkg::*;
#(
   parameter int unsigned DWORD_W = 32,
   parameter int unsigned BEAT_DW = 8,
   localparam int unsigned DATA_W = DWORD_W * BEAT_DW,
   localparam int unsigned HALF_W = DATA_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [DATA_W-1:0]  in_data,
   input  logic [BEAT_DW-1:0] in_keep,
   input  logic               in_last,
   input  logic               in_head_lo,
   input  logic               in_head_hi,
   input  logic [3:0]         in_tail_a,
   input  logic [3:0]         in_tail_b,
   input  logic               in_valid,
   output logic               in_ready,
   output logic [DATA_W-1:0]  out_data,
   output logic [BEAT_DW-1:0] out_keep,
   output logic               out_last,
   output logic               out_valid,
   input  logic               out_ready,
   output logic               err_flag
);
   if (BEAT_DW != LANES) begin : g_bad_lanes
      $error("strsp_splitter: BEAT_DW must equal %0d", LANES);
   end
   if (DWORD_W != 32) begin : g_bad_dword
      $error("strsp_splitter: DWORD_W must be 32");
   end

   strsp_band_t      band;
   logic             first_ok, first_shift, first_last, second_ok;
   logic [LANES-1:0] first_keep, second_keep;
   logic             nx_act, nx_shf, load_carry, bad;
   logic             pick_second, act_q, shf_q;
   logic [HALF_W-1:0] carry_q;
   logic             unused_ok;

   assign unused_ok = ^{in_keep, in_last};
   assign band = '{head_lo: in_head_lo, head_hi: in_head_hi,
                   tail_a: in_tail_a, tail_b: in_tail_b};

   strsp_decode u_dec (
      .band        (band),
      .act         (act_q),
      .shf         (shf_q),
      .first_ok    (first_ok),
      .first_shift (first_shift),
      .first_keep  (first_keep),
      .first_last  (first_last),
      .second_ok   (second_ok),
      .second_keep (second_keep),
      .nx_act      (nx_act),
      .nx_shf      (nx_shf),
      .load_carry  (load_carry),
      .bad         (bad)
   );

   strsp_ctrl #(.HALF_W(HALF_W)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .out_ready   (out_ready),
      .first_ok    (first_ok),
      .second_ok   (second_ok),
      .nx_act      (nx_act),
      .nx_shf      (nx_shf),
      .load_carry  (load_carry),
      .bad         (bad),
      .in_hi       (in_data[DATA_W-1:HALF_W]),
      .in_ready    (in_ready),
      .out_valid   (out_valid),
      .pick_second (pick_second),
      .act_q       (act_q),
      .shf_q       (shf_q),
      .carry_q     (carry_q),
      .err_q       (err_flag)
   );

   // per-Dword output steering
   for (genvar d = 0; d < int'(HALF_LANES); d++) begin : g_lane
      localparam int unsigned LO = d * DWORD_W;
      localparam int unsigned HI = HALF_W + d * DWORD_W;
      always_comb begin
         if (pick_second) begin
            out_data[LO +: DWORD_W] = in_data[HI +: DWORD_W];
            out_data[HI +: DWORD_W] = '0;
         end else if (first_shift) begin
            out_data[LO +: DWORD_W] = carry_q[LO +: DWORD_W];
            out_data[HI +: DWORD_W] = in_data[LO +: DWORD_W];
         end else begin
            out_data[LO +: DWORD_W] = in_data[LO +: DWORD_W];
            out_data[HI +: DWORD_W] = in_data[HI +: DWORD_W];
         end
      end
   end

   assign out_keep = pick_second ? second_keep : first_keep;
   assign out_last = pick_second ? 1'b1 : first_last;

   AST_KEEP_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_keep[0] && ((out_keep & (out_keep + 1'b1)) == '0))); // R6
   AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                     && $stable(out_keep) && $stable(out_last))); // R8
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !act_q && !in_head_lo && !in_head_hi) |-> !out_valid); // R9
endmodule

// File: tb/strsp_splitter_tb_top.sv
`timescale 1ns/1ps
module strsp_splitter_tb_top;
   localparam int NB = 512;
   localparam int NO = 512;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [255:0] in_data = '0;
   logic [7:0]   in_keep = '0;
   logic         in_last = 1'b0;
   logic         in_head_lo = 1'b0, in_head_hi = 1'b0;
   logic [3:0]   in_tail_a = '0, in_tail_b = '0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [255:0] out_data;
   logic [7:0]   out_keep;
   logic         out_last, out_valid;
   logic         out_ready = 1'b0;
   logic         err_flag;

   always #5 clk = ~clk;

   strsp_splitter dut_i (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_keep(in_keep),
      .in_last(in_last), .in_head_lo(in_head_lo), .in_head_hi(in_head_hi),
      .in_tail_a(in_tail_a), .in_tail_b(in_tail_b), .in_valid(in_valid),
      .in_ready(in_ready), .out_data(out_data), .out_keep(out_keep),
      .out_last(out_last), .out_valid(out_valid), .out_ready(out_ready),
      .err_flag(err_flag)
   );

   logic [255:0] ib_data [NB];
   logic         ib_h0 [NB], ib_h1 [NB], ib_idle [NB], st0 [NB];
   logic [3:0]   ib_t0 [NB], ib_t1 [NB];
   int           ch_cnt [NB], cum [NB];
   logic [255:0] eo_data [NO];
   logic [7:0]   eo_keep [NO];
   logic         eo_last [NO];
   int           ch_beat [NO];
   int           nb, no;
   int           n_chk = 0, n_bad = 0;

   function automatic logic [7:0] mask_to(input int n);
      logic [7:0] m;
      for (int i = 0; i < 8; i++) m[i] = (i <= n);
      return m;
   endfunction

   task automatic build();
      int b, p, pid, len, s, beat, pos, nxt;
      logic allow;
      logic [31:0] w;
      logic [3:0] tl;
      for (int j = 0; j < NB; j++) begin
         ib_data[j] = {8{32'hDEAD_0000 | j}};
         ib_h0[j] = 0; ib_h1[j] = 0; ib_idle[j] = 0; st0[j] = 0;
         ib_t0[j] = 0; ib_t1[j] = 0; ch_cnt[j] = 0; cum[j] = 0;
      end
      b = 0; p = 0; pid = 0; nxt = 0; s = 0;
      for (int a = 3; a <= 12; a++)
         for (int c = 3; c <= 12; c++)
            for (int k = 0; k < 2; k++) begin
               len = (k != 0) ? c : a + ((c > 9) ? 9 : 0);
               allow = (pid % 4) != 3;
               if (p != 0) begin
                  if (p <= 4 && allow) s = 4;
                  else begin b++; p = 0; end
               end
               if (p == 0) begin
                  s = 0;
                  if (pid % 5 == 2) begin ib_idle[b] = 1; b++; end
               end
               if (s == 4) begin
                  if (st0[b]) ib_h1[b] = 1; else ib_h0[b] = 1;
               end else begin
                  ib_h0[b] = 1; st0[b] = 1;
               end
               beat = b; pos = s;
               for (int i = 0; i < len; i++) begin
                  w = {8'h5A, pid[11:0], i[11:0]};
                  ib_data[beat][pos*32 +: 32] = w;
                  eo_data[nxt + i/8][(i%8)*32 +: 32] = w;
                  if (i % 8 == 7 || i == len - 1) begin
                     eo_keep[nxt + i/8] = mask_to(i % 8);
                     eo_last[nxt + i/8] = (i == len - 1);
                     ch_beat[nxt + i/8] = beat;
                  end
                  if (i < len - 1) begin
                     pos++;
                     if (pos == 8) begin beat++; pos = 0; end
                  end
               end
               tl = {pos[2:0], 1'b1};
               if (ib_t0[beat][0]) ib_t1[beat] = tl; else ib_t0[beat] = tl;
               nxt += (len + 7) / 8;
               b = beat; p = pos + 1;
               if (p == 8) begin b++; p = 0; end
               pid++;
            end
      nb = (p == 0) ? b : b + 1;
      no = nxt;
      for (int j = 0; j < no; j++) ch_cnt[ch_beat[j]]++;
      for (int j = 0; j < nb; j++) cum[j] = ((j > 0) ? cum[j-1] : 0) + ch_cnt[j];
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
      in_head_lo = 0; in_head_hi = 0; in_tail_a = 0; in_tail_b = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      n_chk++;
      if (out_valid !== 1'b0 || err_flag !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset state out_valid=%b err_flag=%b expected 0 0", out_valid, err_flag);
      end
   endtask

   // drive one beat until accepted with sink always ready
   task automatic send_beat(input logic h0, input logic h1, input logic [3:0] ta, input logic [3:0] tb);
      int guard;
      @(negedge clk);
      out_ready = 1'b1; in_valid = 1'b1; in_data = {8{32'h1234_0000}};
      in_head_lo = h0; in_head_hi = h1; in_tail_a = ta; in_tail_b = tb;
      guard = 0;
      #2;
      while (!in_ready && guard < 20) begin
         @(negedge clk); #2; guard++;
      end
      @(negedge clk);
      in_valid = 1'b0; in_head_lo = 0; in_head_hi = 0; in_tail_a = 0; in_tail_b = 0;
   endtask

   task automatic err_case(input logic h0, input logic h1, input logic [3:0] ta,
                           input logic [3:0] tb, input int id);
      do_reset();
      send_beat(h0, h1, ta, tb);
      #2;
      n_chk++;
      if (err_flag !== 1'b1) begin
         n_bad++;
         $display("FAIL R10 case %0d err_flag=%b expected 1", id, err_flag);
      end
      send_beat(1'b0, 1'b0, 4'h0, 4'h0);   // legal idle beat
      repeat (2) @(negedge clk);
      #2;
      n_chk++;
      if (err_flag !== 1'b1) begin
         n_bad++;
         $display("FAIL R10 sticky case %0d err_flag=%b expected 1", id, err_flag);
      end
   endtask

   initial begin
      logic [15:0] lfsr;
      logic held, stall_prev, mism;
      logic [255:0] st_data;
      logic [7:0] st_keep;
      logic st_last;
      int idx, oidx, cyc;
      build();
      do_reset();
      lfsr = 16'hACE1; held = 0; stall_prev = 0; idx = 0; oidx = 0; cyc = 0;
      st_data = '0; st_keep = '0; st_last = 0;
      while (!(idx == nb && oidx == no) && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = lfsr[0] | lfsr[3];
         if (!held) in_valid = (idx < nb) && (lfsr[5:4] != 2'b00);
         held = in_valid;
         in_keep = lfsr[15:8];          // R7: noise on ignored inputs
         in_last = lfsr[7];
         if (idx < nb) begin
            in_data = ib_data[idx]; in_head_lo = ib_h0[idx]; in_head_hi = ib_h1[idx];
            in_tail_a = ib_t0[idx]; in_tail_b = ib_t1[idx];
         end
         #2;
         if (stall_prev) begin
            n_chk++;
            if (!out_valid || out_data !== st_data || out_keep !== st_keep || out_last !== st_last) begin
               n_bad++;
               $display("FAIL R8 stalled beat changed keep=%h last=%b expected keep=%h last=%b",
                        out_keep, out_last, st_keep, st_last);
            end
         end
         if (out_valid && out_ready) begin
            n_chk++;
            mism = 0;
            if (oidx >= no) mism = 1;
            else begin
               for (int d = 0; d < 8; d++)
                  if (eo_keep[oidx][d] && out_data[d*32 +: 32] !== eo_data[oidx][d*32 +: 32]) mism = 1;
               if (out_keep !== eo_keep[oidx] || out_last !== eo_last[oidx]) mism = 1;
            end
            if (mism) begin
               n_bad++;
               $display("FAIL R2 R3 R4 R6 R7 R11 out beat %0d keep=%h last=%b dw0=%h expected keep=%h last=%b dw0=%h",
                        oidx, out_keep, out_last, out_data[31:0],
                        (oidx < no) ? eo_keep[oidx] : 8'h0, (oidx < no) ? eo_last[oidx] : 1'b0,
                        (oidx < no) ? eo_data[oidx][31:0] : 32'h0);
            end
            oidx++;
         end
         stall_prev = out_valid && !out_ready;
         st_data = out_data; st_keep = out_keep; st_last = out_last;
         if (in_valid && idx < nb && ib_idle[idx]) begin
            n_chk++;
            if (out_valid) begin
               n_bad++;
               $display("FAIL R9 idle beat %0d out_valid=%b expected 0", idx, out_valid);
            end
         end
         if (in_valid && in_ready) begin
            n_chk++;
            if (oidx != cum[idx]) begin
               n_bad++;
               $display("FAIL R5 beat %0d consumed after %0d outputs expected %0d", idx, oidx, cum[idx]);
            end
            idx++;
            held = 0;
         end
      end
      in_valid = 1'b0;
      n_chk++;
      if (cyc >= 20000) begin
         n_bad++;
         $display("FAIL watchdog R5 consumed %0d of %0d beats, %0d of %0d outputs", idx, nb, oidx, no);
      end
      // R10: inconsistent sideband
      err_case(1'b0, 1'b1, 4'h0, 4'h0, 1);                   // head_hi alone
      err_case(1'b0, 1'b0, 4'h0, 4'b1111, 2);                // tail_b without tail_a
      err_case(1'b1, 1'b1, 4'b0011, 4'b1011, 3);             // tail_b offset 5
      do_reset();
      // legal double packet beat keeps err clear
      send_beat(1'b1, 1'b1, 4'b0101, 4'b1111);
      #2;
      n_chk++;
      if (err_flag !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 legal pair beat err_flag=%b expected 0", err_flag);
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule